// File: doc/BRIEF.md
# Segmented Memory Controller with Delayed Strobes

This block sits between a small accumulator processor and its memories. The processor presents a storage address register value, a storage data register value and read and write strobes. The controller decodes the address into one of several regions: a 16-bit heap RAM, a write-only 16-bit framebuffer port, a read-only keyboard code register and a 24-bit program ROM. Address zero is special. A read there returns a fixed jump into the ROM, so that execution starts in the ROM.

The processor raises a strobe in the same cycle in which it writes the address or data register. The registers take their new value one clock later. For that reason the controller delays each strobe by one cycle before acting on it. A request lasts three cycles. The controller performs the single memory access in the first delayed cycle and ignores the other two. Every backing memory has one cycle of read latency. Read data is presented with a one-cycle load pulse, so that the processor's data register holds it at the start of the fourth request cycle. The load pulse is never raised for anything but a read, because the processor also uses that register as scratch storage.

Top module: `seg_mem_ctrl`

## Requirements
- R1: Address decode: 0x00001..0x03FFF is heap (index = address bits 13:0), 0x04000..0x05FFF is framebuffer (index = bits 12:0), 0x06000 is the keyboard register, 0x08000..0x0FFFF is ROM (index = bits 14:0). A ROM read returns the 24-bit ROM word unchanged.
- R2: A heap read returns the 16-bit heap word zero-extended to 24 bits. A heap write stores the low 16 bits of the data input.
- R3: A framebuffer write drives the framebuffer port with the low 16 bits of the data input. A framebuffer read returns zero.
- R4: A keyboard read returns the 8-bit key code zero-extended to 24 bits.
- R5: A read of address 0 returns 0x808000 (opcode 8, jump, to 0x08000).
- R6: Strobes are delayed one cycle. The access uses the address and data present in the cycle after the strobe first rises, not those of the strobe's first cycle.
- R7: Each 3-cycle strobe period makes exactly one access, in its first delayed cycle. A strobe held for 6 cycles is two requests, the second using the address present in its own first delayed cycle.
- R8: For a read whose strobe first rises in cycle c, the load output is high only in cycle c+2 and carries the read data.
- R9: The load output is never high except as the result of a read. Write requests never raise it.
- R10: Writes to ROM, the keyboard register, address 0 or unmapped addresses drive no memory write. Reads of unmapped addresses (0x06001..0x07FFF, at or above 0x10000) return zero.
- R11: In reset and right after it, the load output, the heap enable, the ROM enable and the framebuffer write are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sar_i | input | 20 | Processor storage address register |
| sdr_i | input | 24 | Processor storage data register |
| rd_req_i | input | 1 | Read strobe, undelayed |
| wr_req_i | input | 1 | Write strobe, undelayed |
| sdr_load_o | output | 1 | Load pulse for the processor data register |
| sdr_data_o | output | 24 | Read data for the processor data register |
| heap_en_o | output | 1 | Heap access enable |
| heap_we_o | output | 1 | Heap write enable |
| heap_addr_o | output | 14 | Heap word index |
| heap_wdata_o | output | 16 | Heap write data |
| heap_rdata_i | input | 16 | Heap read data, one cycle after enable |
| fb_we_o | output | 1 | Framebuffer write enable |
| fb_addr_o | output | 13 | Framebuffer word index |
| fb_wdata_o | output | 16 | Framebuffer pixel word |
| key_code_i | input | 8 | Last key code |
| rom_en_o | output | 1 | ROM read enable |
| rom_addr_o | output | 15 | ROM word index |
| rom_rdata_i | input | 24 | ROM read data, one cycle after enable |

## Verification
The hardest case to reach is two requests with no gap between them. One is a 6-cycle read strobe whose second address appears only in its fourth cycle. The other is a write followed at once by a read. Both can fail only if the strobe phase tracking is wrong. The stimulus tasks therefore hand the bus over in the same cycle and chain two reads on one continuous strobe. In the first cycle of every request they drive a decoy address and decoy data that map to another live region, so a controller that uses the undelayed strobe writes to, or reads from, a visibly wrong place.

// File: rtl/mseg_pkg.sv
package mseg_pkg;
    localparam int ADDR_W  = 20;
    localparam int WORD_W  = 24;
    localparam int HALF_W  = 16;
    localparam int KEY_W   = 8;
    localparam int HEAP_AW = 14;
    localparam int FB_AW   = 13;
    localparam int ROM_AW  = 15;
    localparam int REQ_LEN = 3;

    localparam logic [ADDR_W-1:0] HEAP_LO = 20'h00001;
    localparam logic [ADDR_W-1:0] HEAP_HI = 20'h03FFF;
    localparam logic [ADDR_W-1:0] FB_LO   = 20'h04000;
    localparam logic [ADDR_W-1:0] FB_HI   = 20'h05FFF;
    localparam logic [ADDR_W-1:0] KEY_AT  = 20'h06000;
    localparam logic [ADDR_W-1:0] ROM_LO  = 20'h08000;
    localparam logic [ADDR_W-1:0] ROM_HI  = 20'h0FFFF;
    localparam logic [3:0]        JUMP_OP = 4'h8;
    localparam logic [WORD_W-1:0] BOOT_WORD = {JUMP_OP, ROM_LO};

    typedef enum logic [2:0] {
        RG_NONE, RG_BOOT, RG_HEAP, RG_FB, RG_KEY, RG_ROM
    } region_e;

    function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
        region_e r;
        if (a == '0)                          r = RG_BOOT;
        else if (a >= HEAP_LO && a <= HEAP_HI) r = RG_HEAP;
        else if (a >= FB_LO && a <= FB_HI)     r = RG_FB;
        else if (a == KEY_AT)                  r = RG_KEY;
        else if (a >= ROM_LO && a <= ROM_HI)   r = RG_ROM;
        else                                   r = RG_NONE;
        return r;
    endfunction
endpackage

// File: rtl/mseg_strobe_delay.sv
module mseg_strobe_delay #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic go_o
);
    localparam int PH_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(LEN - 1);

    logic            req_q;
    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            phase_q <= '0;
        end else begin
            req_q <= req_i;
            if (!req_q || phase_q == PH_LAST)
                phase_q <= '0;
            else
                phase_q <= phase_q + 1'b1;
        end
    end

    assign go_o = req_q && (phase_q == '0);

    a_r7_phase_in_range: assert property (@(posedge clk) disable iff (rst)
        phase_q <= PH_LAST);
    a_r6_go_after_strobe: assert property (@(posedge clk) disable iff (rst)
        go_o |-> $past(req_i));
endmodule

// File: rtl/mseg_port_drive.sv
module mseg_port_drive
    import mseg_pkg::*;
(
    input  logic                rd_go_i,
    input  logic                wr_go_i,
    input  region_e             rg_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [HALF_W-1:0]   wdata_i,
    output logic                heap_en_o,
    output logic                heap_we_o,
    output logic [HEAP_AW-1:0]  heap_addr_o,
    output logic [HALF_W-1:0]   heap_wdata_o,
    output logic                fb_we_o,
    output logic [FB_AW-1:0]    fb_addr_o,
    output logic [HALF_W-1:0]   fb_wdata_o,
    output logic                rom_en_o,
    output logic [ROM_AW-1:0]   rom_addr_o
);
    always_comb begin
        heap_en_o = (rd_go_i || wr_go_i) && (rg_i == RG_HEAP);
        heap_we_o = wr_go_i && (rg_i == RG_HEAP);
        fb_we_o   = wr_go_i && (rg_i == RG_FB);
        rom_en_o  = rd_go_i && (rg_i == RG_ROM);
    end

    assign heap_addr_o  = addr_i[HEAP_AW-1:0];
    assign fb_addr_o    = addr_i[FB_AW-1:0];
    assign rom_addr_o   = addr_i[ROM_AW-1:0];
    assign heap_wdata_o = wdata_i;
    assign fb_wdata_o   = wdata_i;
endmodule

// File: rtl/mseg_read_return.sv
module mseg_read_return
    import mseg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_go_i,
    input  region_e            rg_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [HALF_W-1:0]  heap_rdata_i,
    input  logic [WORD_W-1:0]  rom_rdata_i,
    output logic               load_o,
    output logic [WORD_W-1:0]  data_o
);
    logic              pend_q;
    region_e           rg_q;
    logic [KEY_W-1:0]  key_q;
    logic [WORD_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            rg_q   <= RG_NONE;
            key_q  <= '0;
        end else begin
            pend_q <= rd_go_i;
            if (rd_go_i) begin
                rg_q  <= rg_i;
                key_q <= key_i;
            end
        end
    end

    always_comb begin
        unique case (rg_q)
            RG_HEAP: sel = {{(WORD_W-HALF_W){1'b0}}, heap_rdata_i};
            RG_ROM:  sel = rom_rdata_i;
            RG_KEY:  sel = {{(WORD_W-KEY_W){1'b0}}, key_q};
            RG_BOOT: sel = BOOT_WORD;
            default: sel = '0;
        endcase
    end

    assign load_o = pend_q;
    assign data_o = pend_q ? sel : '0;

    a_r8_load_single_cycle: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o);
    a_r8_load_follows_issue: assert property (@(posedge clk) disable iff (rst)
        load_o |-> $past(rd_go_i));
endmodule

// File: rtl/seg_mem_ctrl.sv
module seg_mem_ctrl
    import mseg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   sar_i,
    input  logic [WORD_W-1:0]   sdr_i,
    input  logic                rd_req_i,
    input  logic                wr_req_i,
    output logic                sdr_load_o,
    output logic [WORD_W-1:0]   sdr_data_o,
    output logic                heap_en_o,
    output logic                heap_we_o,
    output logic [HEAP_AW-1:0]  heap_addr_o,
    output logic [HALF_W-1:0]   heap_wdata_o,
    input  logic [HALF_W-1:0]   heap_rdata_i,
    output logic                fb_we_o,
    output logic [FB_AW-1:0]    fb_addr_o,
    output logic [HALF_W-1:0]   fb_wdata_o,
    input  logic [KEY_W-1:0]    key_code_i,
    output logic                rom_en_o,
    output logic [ROM_AW-1:0]   rom_addr_o,
    input  logic [WORD_W-1:0]   rom_rdata_i
);
    logic    rd_go, wr_go;
    region_e rg;

    assign rg = decode_region(sar_i);

    mseg_strobe_delay #(.LEN(REQ_LEN)) u_rd_dly (
        .clk(clk), .rst(rst), .req_i(rd_req_i), .go_o(rd_go));
    mseg_strobe_delay #(.LEN(REQ_LEN)) u_wr_dly (
        .clk(clk), .rst(rst), .req_i(wr_req_i), .go_o(wr_go));

    mseg_port_drive u_drive (
        .rd_go_i(rd_go), .wr_go_i(wr_go), .rg_i(rg),
        .addr_i(sar_i), .wdata_i(sdr_i[HALF_W-1:0]),
        .heap_en_o(heap_en_o), .heap_we_o(heap_we_o),
        .heap_addr_o(heap_addr_o), .heap_wdata_o(heap_wdata_o),
        .fb_we_o(fb_we_o), .fb_addr_o(fb_addr_o), .fb_wdata_o(fb_wdata_o),
        .rom_en_o(rom_en_o), .rom_addr_o(rom_addr_o));

    mseg_read_return u_ret (
        .clk(clk), .rst(rst), .rd_go_i(rd_go), .rg_i(rg),
        .key_i(key_code_i), .heap_rdata_i(heap_rdata_i),
        .rom_rdata_i(rom_rdata_i),
        .load_o(sdr_load_o), .data_o(sdr_data_o));

    a_r9_load_needs_read: assert property (@(posedge clk) disable iff (rst)
        sdr_load_o |-> $past(rd_req_i, 2));
    a_r3_fb_write_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        fb_we_o |-> $past(wr_req_i));
    a_r7_one_write_per_request: assert property (@(posedge clk) disable iff (rst)
        (fb_we_o || heap_we_o) |=> !(fb_we_o || heap_we_o));
    a_r1_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({heap_en_o, fb_we_o, rom_en_o}));
endmodule

// File: tb/test_seg_mem_ctrl.sv
module test_seg_mem_ctrl;
    localparam int PERIOD = 10;
    localparam logic [19:0] DECOY_A = 20'h04ABC;
    localparam logic [23:0] DECOY_D = 24'hF0F0F0;

    logic        clk = 1'b0, rst = 1'b1;
    logic [19:0] sar = '0;
    logic [23:0] sdr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic        sdr_load_o, heap_en_o, heap_we_o, fb_we_o, rom_en_o;
    logic [23:0] sdr_data_o, rom_rdata;
    logic [13:0] heap_addr_o;
    logic [15:0] heap_wdata_o, heap_rdata;
    logic [12:0] fb_addr_o;
    logic [15:0] fb_wdata_o;
    logic [14:0] rom_addr_o;
    logic [7:0]  key = 8'h00;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit mon_on = 1'b0, done = 1'b0;

    logic [15:0] heap_m [int];
    logic [15:0] ref_heap [int];
    logic [23:0] exp_load [int];
    string       tag_load [int];
    logic [28:0] exp_fb [int];
    string       tag_fb [int];
    logic [29:0] exp_hw [int];
    string       tag_hw [int];

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seg_mem_ctrl i_seg_mem_ctrl (
        .clk(clk), .rst(rst), .sar_i(sar), .sdr_i(sdr),
        .rd_req_i(rd), .wr_req_i(wr),
        .sdr_load_o(sdr_load_o), .sdr_data_o(sdr_data_o),
        .heap_en_o(heap_en_o), .heap_we_o(heap_we_o),
        .heap_addr_o(heap_addr_o), .heap_wdata_o(heap_wdata_o),
        .heap_rdata_i(heap_rdata),
        .fb_we_o(fb_we_o), .fb_addr_o(fb_addr_o), .fb_wdata_o(fb_wdata_o),
        .key_code_i(key),
        .rom_en_o(rom_en_o), .rom_addr_o(rom_addr_o), .rom_rdata_i(rom_rdata));

    function automatic logic [23:0] rom_word(input logic [14:0] a);
        logic [23:0] x;
        x = ({9'd0, a} * 24'd40503) ^ 24'h5A5A5A;
        return x;
    endfunction

    // memory models: one cycle of read latency
    always @(posedge clk) begin
        if (heap_en_o && heap_we_o) heap_m[int'(heap_addr_o)] = heap_wdata_o;
        else if (heap_en_o) heap_rdata <= heap_m.exists(int'(heap_addr_o)) ? heap_m[int'(heap_addr_o)] : 16'h0;
        if (rom_en_o) rom_rdata <= rom_word(rom_addr_o);
    end

    function automatic int kind(input logic [19:0] a); // 0 none 1 boot 2 heap 3 fb 4 key 5 rom
        int v;
        v = int'(a);
        if (v == 0) return 1;
        if (v < 16384) return 2;
        if (v < 24576) return 3;
        if (v == 24576) return 4;
        if (v >= 32768 && v < 65536) return 5;
        return 0;
    endfunction

    function automatic logic [23:0] ref_read(input logic [19:0] a);
        int idx;
        idx = int'(a[13:0]);
        case (kind(a))
            1: return 24'h808000;
            2: return ref_heap.exists(idx) ? {8'h00, ref_heap[idx]} : 24'h0;
            4: return {16'h0, key};
            5: return rom_word(a[14:0]);
            default: return 24'h0;
        endcase
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic fail_line(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_bad++;
        $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    endtask

    // per-cycle comparison against the reference expectations
    always @(negedge clk) if (mon_on) begin
        n_cmp++;
        if (exp_load.exists(cyc)) begin
            if (sdr_load_o !== 1'b1 || sdr_data_o !== exp_load[cyc])
                fail_line(tag_load[cyc], "load", {7'd0, sdr_load_o, sdr_data_o}, {8'h01, exp_load[cyc]});
        end else if (sdr_load_o !== 1'b0)
            fail_line("R9", "unexpected load", {31'd0, sdr_load_o}, 32'd0);
        n_cmp++;
        if (exp_fb.exists(cyc)) begin
            if (fb_we_o !== 1'b1 || {fb_addr_o, fb_wdata_o} !== exp_fb[cyc])
                fail_line(tag_fb[cyc], "fb write", {3'd0, fb_addr_o, fb_wdata_o}, {3'd0, exp_fb[cyc]});
        end else if (fb_we_o !== 1'b0)
            fail_line("R10", "unexpected fb write", {3'd0, fb_addr_o, fb_wdata_o}, 32'd0);
        n_cmp++;
        if (exp_hw.exists(cyc)) begin
            if (heap_we_o !== 1'b1 || heap_en_o !== 1'b1 || {heap_addr_o, heap_wdata_o} !== exp_hw[cyc])
                fail_line(tag_hw[cyc], "heap write", {2'd0, heap_addr_o, heap_wdata_o}, {2'd0, exp_hw[cyc]});
        end else if (heap_we_o === 1'b1 && heap_en_o === 1'b1)
            fail_line("R10", "unexpected heap write", {2'd0, heap_addr_o, heap_wdata_o}, 32'd0);
    end

    task automatic do_rd(input logic [19:0] a, input string tag);
        int c;
        c = cyc;
        exp_load[c+2] = ref_read(a);
        tag_load[c+2] = tag;
        rd = 1'b1; sar = DECOY_A;
        step(); sar = a;
        step(); step(); rd = 1'b0;
    endtask

    task automatic do_rd2(input logic [19:0] a1, input logic [19:0] a2, input string tag);
        int c;
        c = cyc;
        exp_load[c+2] = ref_read(a1); tag_load[c+2] = tag;
        exp_load[c+5] = ref_read(a2); tag_load[c+5] = tag;
        rd = 1'b1; sar = DECOY_A;
        step(); sar = a1;
        step(); step(); step(); sar = a2;
        step(); step(); rd = 1'b0;
    endtask

    task automatic do_wr(input logic [19:0] a, input logic [23:0] d, input string tag);
        int c;
        c = cyc;
        if (kind(a) == 2) begin
            exp_hw[c+1] = {a[13:0], d[15:0]}; tag_hw[c+1] = tag;
            ref_heap[int'(a[13:0])] = d[15:0];
        end else if (kind(a) == 3) begin
            exp_fb[c+1] = {a[12:0], d[15:0]}; tag_fb[c+1] = tag;
        end
        wr = 1'b1; sar = DECOY_A; sdr = DECOY_D;
        step(); sar = a; sdr = d;
        step(); step(); wr = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        n_cmp++;
        if ({sdr_load_o, heap_en_o, rom_en_o, fb_we_o} !== 4'b0)
            fail_line("R11", "reset outputs", {28'd0, sdr_load_o, heap_en_o, rom_en_o, fb_we_o}, 32'd0);
        rst = 1'b0;
        step();
        mon_on = 1'b1;
        step();
        n_cmp++;
        if ({sdr_load_o, heap_en_o, rom_en_o, fb_we_o} !== 4'b0)
            fail_line("R11", "after reset", {28'd0, sdr_load_o, heap_en_o, rom_en_o, fb_we_o}, 32'd0);

        do_rd(20'h00000, "R5");
        step();
        do_wr(20'h00010, 24'hABCD12, "R2");
        do_rd(20'h00010, "R2");
        do_wr(20'h03FFF, 24'h00FFEE, "R1");
        do_rd(20'h03FFF, "R1");
        do_wr(20'h00001, 24'h7F8001, "R1");
        do_rd(20'h00001, "R1");
        do_wr(20'h04000, 24'h12BEEF, "R3");
        do_wr(20'h05FFF, 24'h345678, "R3");
        do_rd(20'h04000, "R3");
        key = 8'h41;
        do_rd(20'h06000, "R4");
        do_wr(20'h06000, 24'h000099, "R10");
        key = 8'hFE;
        do_rd(20'h06000, "R4");
        do_rd(20'h08000, "R1");
        do_rd(20'h0FFFF, "R1");
        do_wr(20'h08005, 24'h111111, "R10");
        do_rd(20'h08005, "R10");
        do_wr(20'h10001, 24'h222222, "R10");
        do_rd(20'h00001, "R10");
        do_wr(20'h00000, 24'h333333, "R10");
        do_rd(20'h00000, "R10");
        do_rd(20'h10000, "R10");
        do_rd(20'h06001, "R10");
        do_rd(20'h07FFF, "R10");
        do_rd2(20'h00010, 20'h08001, "R7");
        do_rd2(20'h00000, 20'h03FFF, "R7");
        do_wr(20'h00200, 24'hC0FFEE, "R6");
        do_rd(20'h00200, "R6");
        do_wr(20'h04321, 24'h00A5A5, "R6");
        do_wr(20'h00201, 24'h001234, "R7");
        do_rd2(20'h00201, 20'h00200, "R8");
        repeat (6) step();
        done = 1'b1;
        summary();
    end
endmodule